// File: doc/BRIEF.md
# LED Pixel Transmit Queue Front End

This block is the register-facing side of an addressable-LED serial controller. Software, or a DMA engine, pushes 32-bit pixel words into a transmit queue through a data register. A serial encoder outside this block drains the queue one word at a time, and it signals when a whole frame has gone out. The encoder also pulses a start strobe at the beginning of each frame, and that strobe empties the queue.

The block has two ways to ask for refills, and a programmable fill threshold drives both. With DMA disabled, a CPU-request status flag is raised while the queue holds no more words than the threshold. With DMA enabled, a DMA request line is held high while the free space is at least the threshold. A small interrupt unit holds three sticky status flags: frame done, CPU request and queue overflow. Two of them have their own enables, and a global enable gates the interrupt line. Software clears a flag by writing a one to it. The status register also returns the live queue fill level.

The register bus uses a write strobe, a read strobe and a 4-bit byte address. Offsets are 0x0 data, 0x4 DMA control, 0x8 interrupt control and 0xC status. Read data appears on the cycle after the read strobe.

Top module: `led_txq_front`

## Requirements
- R1: The queue holds 32 words of 32 bits. Words leave in the order they were written. `pop_data_o` shows the oldest word while `pop_valid_o` is high, and a pop while empty has no effect.
- R2: A data-register write while the queue holds 32 words is dropped. It sets the overflow flag, status bit 2, which stays set until cleared.
- R3: A pulse on `xfer_start_i` empties the queue, so the fill level reads 0 and `pop_valid_o` is low on the next cycle.
- R4: Status bits 15:10 return the current number of queued words (0 to 32).
- R5: The DMA control register (0x4) holds a DMA enable in bit 5 and a 5-bit threshold in bits 4:0. It resets to enable 0 and threshold 16, and reads back what was written.
- R6: `dma_req_o` is high exactly when DMA is enabled and (32 − fill level) ≥ threshold.
- R7: Status bit 1 (CPU request) is set on every cycle in which DMA is disabled and fill level ≤ threshold. It is never set while DMA is enabled.
- R8: A pulse on `xfer_done_i` sets status bit 0 (frame done).
- R9: Writing status (0xC) clears each flag whose written bit is 1 and leaves a flag whose written bit is 0 unchanged. If a flag's set condition holds in the same cycle as its clear, the flag stays set.
- R10: The interrupt control register (0x8) holds a global enable in bit 5, a CPU-request enable in bit 1 and a frame-done enable in bit 0, and resets to 0. `irq_o` = global & ((bit0 flag & bit0 enable) | (bit1 flag & bit1 enable)).
- R11: A read of the data register (0x0) returns 0. All reads return data on the cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| pop_i | input | 1 | Encoder takes the oldest queued word |
| pop_data_o | output | 32 | Oldest queued word |
| pop_valid_o | output | 1 | Queue not empty |
| xfer_start_i | input | 1 | Frame start pulse; empties the queue |
| xfer_done_i | input | 1 | Frame finished pulse |
| dma_req_o | output | 1 | DMA refill request |
| irq_o | output | 1 | Interrupt line |

## Verification
The queue is run with a short burst and drained, which checks ordering and the fill field. It is then filled past capacity, which separates a dropped 33rd word from an overwrite and exercises the overflow flag. A threshold of 8 with DMA on is stepped through 24 and 25 queued words to find the exact edge of the DMA request. With DMA off and a threshold of 4, popping from 5 to 4 words shows the CPU request reasserting at "at or below". The interrupt tests toggle each enable and the global gate separately, and they collide a frame-done pulse with its own clear to show that the set wins.

// File: rtl/led_txq_pkg.sv
package led_txq_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_DMA  = 2'd1,
    REG_IRQ  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Bit positions decoded by software
  localparam int unsigned BIT_DONE   = 0;
  localparam int unsigned BIT_CPUREQ = 1;
  localparam int unsigned BIT_OVF    = 2;
  localparam int unsigned BIT_DMA_EN = 5;
  localparam int unsigned BIT_GIE    = 5;
  localparam int unsigned FILL_LSB   = 10;
  localparam int unsigned NUM_FLAGS  = 3;
endpackage

// File: rtl/led_txq_fifo.sv
module led_txq_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             drop_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, push_ok, pop_ok;

  assign full    = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign drop_o  = push_i & full & ~flush_i;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R1
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !flush_i) |=> (cnt_q == FULL) && $stable(wr_ptr_q)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R3
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o && $stable(rd_ptr_q)); // R1
endmodule

// File: rtl/led_txq_regs.sv
module led_txq_regs
  import led_txq_pkg::*;
#(
  parameter int unsigned TRIG_W   = 5,
  parameter int unsigned TRIG_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_sel_e          sel_i,
  input  logic [31:0]       wdata_i,
  output logic              dma_en_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic              gie_o,
  output logic              en_req_o,
  output logic              en_done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_o  <= 1'b0;
      trig_o    <= TRIG_W'(TRIG_RST);
      gie_o     <= 1'b0;
      en_req_o  <= 1'b0;
      en_done_o <= 1'b0;
    end else if (wr_en_i) begin
      if (sel_i == REG_DMA) begin
        dma_en_o <= wdata_i[BIT_DMA_EN];
        trig_o   <= wdata_i[TRIG_W-1:0];
      end
      if (sel_i == REG_IRQ) begin
        gie_o     <= wdata_i[BIT_GIE];
        en_req_o  <= wdata_i[BIT_CPUREQ];
        en_done_o <= wdata_i[BIT_DONE];
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(trig_o) && $stable(dma_en_o) && $stable(gie_o)); // R5
endmodule

// File: rtl/led_txq_irq.sv
module led_txq_irq
  import led_txq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic                 gie_i,
  input  logic                 en_req_i,
  input  logic                 en_done_i,
  output logic [NUM_FLAGS-1:0] stat_o,
  output logic                 irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | set_i;
  end

  assign irq_o = gie_i & ((stat_o[BIT_DONE] & en_done_i) |
                          (stat_o[BIT_CPUREQ] & en_req_i));

  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[BIT_DONE] |=> stat_o[BIT_DONE]); // R8
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[BIT_DONE] && !set_i[BIT_DONE]) |=> !stat_o[BIT_DONE]); // R9
  AST_W1C_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[BIT_OVF] && !clr_i[BIT_OVF]) |=> stat_o[BIT_OVF]); // R9
endmodule

// File: rtl/led_txq_front.sv
module led_txq_front
  import led_txq_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned TRIG_W   = 5,
  parameter int unsigned TRIG_RST = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              pop_i,
  output logic [WIDTH-1:0]  pop_data_o,
  output logic              pop_valid_o,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  output logic              dma_req_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  reg_sel_e             sel;
  logic [CNT_W-1:0]     count, free_sp, trig_ext;
  logic                 empty, drop;
  logic                 dma_en, gie, en_req, en_done;
  logic [TRIG_W-1:0]    trig;
  logic [NUM_FLAGS-1:0] set_v, clr_v, stat;
  logic [31:0]          rd_mux;

  assign sel = reg_sel_e'(addr_i[3:2]);

  led_txq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (xfer_start_i),
    .push_i  (wr_en_i && sel == REG_DATA),
    .wdata_i (wdata_i[WIDTH-1:0]),
    .pop_i   (pop_i),
    .rdata_o (pop_data_o),
    .count_o (count),
    .empty_o (empty),
    .drop_o  (drop)
  );

  led_txq_regs #(.TRIG_W(TRIG_W), .TRIG_RST(TRIG_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i),
    .dma_en_o  (dma_en),
    .trig_o    (trig),
    .gie_o     (gie),
    .en_req_o  (en_req),
    .en_done_o (en_done)
  );

  assign trig_ext  = CNT_W'(trig);
  assign free_sp   = FULL - count;
  assign dma_req_o = dma_en & (free_sp >= trig_ext);

  always_comb begin
    set_v             = '0;
    set_v[BIT_DONE]   = xfer_done_i;
    set_v[BIT_CPUREQ] = ~dma_en & (count <= trig_ext);
    set_v[BIT_OVF]    = drop;
    clr_v = (wr_en_i && sel == REG_STAT) ? wdata_i[NUM_FLAGS-1:0] : '0;
  end

  led_txq_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_v),
    .clr_i     (clr_v),
    .gie_i     (gie),
    .en_req_i  (en_req),
    .en_done_i (en_done),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  assign pop_valid_o = ~empty;

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_DMA: begin
        rd_mux[BIT_DMA_EN]   = dma_en;
        rd_mux[TRIG_W-1:0]   = trig;
      end
      REG_IRQ: begin
        rd_mux[BIT_GIE]    = gie;
        rd_mux[BIT_CPUREQ] = en_req;
        rd_mux[BIT_DONE]   = en_done;
      end
      REG_STAT: begin
        rd_mux[NUM_FLAGS-1:0]       = stat;
        rd_mux[FILL_LSB +: CNT_W]   = count;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  AST_DMA_NO_CPUREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dma_en) && $past(dma_en, 2) && !$past(stat[BIT_CPUREQ])) |-> !stat[BIT_CPUREQ]); // R7
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat[BIT_CPUREQ]) |-> stat[BIT_DONE]); // R10
endmodule

// File: tb/led_txq_front_tb.sv
module led_txq_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pop = 1'b0;
  logic [31:0] pop_data;
  logic        pop_valid;
  logic        start = 1'b0, done = 1'b0;
  logic        dma_req, irq;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  led_txq_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pop_i(pop),
    .pop_data_o(pop_data), .pop_valid_o(pop_valid), .xfer_start_i(start),
    .xfer_done_i(done), .dma_req_o(dma_req), .irq_o(irq)
  );

  localparam logic [3:0] A_DATA = 4'h0, A_DMA = 4'h4, A_IRQ = 4'h8, A_STAT = 4'hC;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    idle(2);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_DMA, d);  check("R5 dma ctrl reset", d, 32'h10);
    rd(A_IRQ, d);  check("R10 irq ctrl reset", d, 32'h0);
    rd(A_STAT, d); check("R7 status after reset", d, 32'h2);
    check("R10 irq low", {31'b0, irq}, 0);
    check("R6 dma_req low", {31'b0, dma_req}, 0);
    check("R1 empty", {31'b0, pop_valid}, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) wr(A_DATA, 32'hA500_0000 + i);
    rd(A_STAT, d); check("R4 fill 5", (d >> 10) & 32'h3F, 5);
    rd(A_DATA, d); check("R11 data reads 0", d, 0);
    for (int i = 0; i < 5; i++) begin
      check("R1 valid", {31'b0, pop_valid}, 1);
      check("R1 order", pop_data, 32'hA500_0000 + i);
      do_pop();
    end
    check("R1 drained", {31'b0, pop_valid}, 0);
    do_pop();
    rd(A_STAT, d); check("R1 pop on empty", (d >> 10) & 32'h3F, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) wr(A_DATA, 32'h100 + i);
    rd(A_STAT, d); check("R2 no ovf at 32", d & 32'h4, 0);
    check("R4 fill 32", (d >> 10) & 32'h3F, 32);
    wr(A_DATA, 32'hDEAD);
    rd(A_STAT, d); check("R2 ovf set", d & 32'h4, 32'h4);
    check("R2 fill stays 32", (d >> 10) & 32'h3F, 32);
    check("R2 head kept", pop_data, 32'h100);
    for (int i = 0; i < 31; i++) do_pop();
    check("R2 last word not overwritten", pop_data, 32'h11F);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R9 zero write keeps ovf", d & 32'h4, 32'h4);
    wr(A_STAT, 32'h4);
    rd(A_STAT, d); check("R9 ovf cleared", d & 32'h4, 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) wr(A_DATA, i);
    flush();
    check("R3 empty after start", {31'b0, pop_valid}, 0);
    rd(A_STAT, d); check("R3 fill 0", (d >> 10) & 32'h3F, 0);
  endtask

  task automatic t_dma();
    logic [31:0] d;
    wr(A_DMA, 32'h28);
    rd(A_DMA, d); check("R5 readback", d, 32'h28);
    check("R6 req at empty", {31'b0, dma_req}, 1);
    wr(A_STAT, 32'h2);
    for (int i = 0; i < 24; i++) wr(A_DATA, i);
    idle(1); check("R6 req at free 8", {31'b0, dma_req}, 1);
    wr(A_DATA, 32'h55);
    idle(1); check("R6 no req at free 7", {31'b0, dma_req}, 0);
    flush();
    rd(A_STAT, d); check("R7 no cpureq with dma", d & 32'h2, 0);
    wr(A_DMA, 32'h04);
    idle(1); check("R6 no req dma off", {31'b0, dma_req}, 0);
  endtask

  task automatic t_cpureq();
    logic [31:0] d;
    rd(A_STAT, d); check("R7 set at fill 0 trig 4", d & 32'h2, 32'h2);
    for (int i = 0; i < 5; i++) wr(A_DATA, i);
    wr(A_STAT, 32'h2);
    rd(A_STAT, d); check("R7 clear holds above trig", d & 32'h2, 0);
    do_pop();
    rd(A_STAT, d); check("R7 set at fill == trig", d & 32'h2, 32'h2);
    flush();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_IRQ, 32'h01);
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    rd(A_STAT, d); check("R8 done set", d & 32'h1, 1);
    check("R10 no irq without global", {31'b0, irq}, 0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); check("R9 zero write keeps done", d & 32'h1, 1);
    wr(A_IRQ, 32'h21);
    idle(1); check("R10 irq done", {31'b0, irq}, 1);
    wr(A_STAT, 32'h1);
    idle(1); check("R10 irq drops after clear", {31'b0, irq}, 0);
    wr(A_IRQ, 32'h22);
    idle(1); check("R10 irq cpureq", {31'b0, irq}, 1);
    wr(A_IRQ, 32'h02);
    idle(1); check("R10 global gate", {31'b0, irq}, 0);
    @(negedge clk);
    wr_en = 1'b1; addr = A_STAT; wdata = 32'h1; done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0;
    rd(A_STAT, d); check("R9 set wins over clear", d & 32'h1, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_overflow();
    t_flush();
    t_dma();
    t_cpureq();
    t_irq();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule